// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a framed serial bit stream into parallel words for a host. An external bit clock, an external active-high frame sync and a serial data line enter the block. All three are brought into the system clock domain and oversampled there. Each frame carries a fixed number of fixed-width words in a single phase. The block captures them most significant bit first and writes every finished word into a 32-bit buffer, right-justified and sign-extended.

The host learns that a word is waiting through a ready flag and a one-cycle interrupt pulse. It takes the word with a one-cycle read strobe. Two sticky flags report trouble. The overrun flag means a word was overwritten before the host read it. The sync-error flag means a frame sync cut a frame short. A synchronous reset input holds the receiver idle and clears every flag.

Top module: `framed_serial_rx`

## Requirements
- R1: While `rxReset` is high, the block ignores the data and sync lines. `readyOut`, `irqOut`, `overrunOut`, `syncErrOut` and `bufferOut` all read 0 from the cycle after `rxReset` is sampled high, and they stay at 0 while it is held.
- R2: The data and sync lines are sampled only at falling edges of `bitClk`. A frame starts at a falling edge where `frameSync` reads 1 after having read 0 at the previous falling edge. The first data bit is taken at the next falling edge (one bit of delay), so the data bit that shares the sync edge is discarded.
- R3: Words are `WORD_BITS` (16) wide and arrive most significant bit first. A frame holds `WORDS_PER_FRAME` (2) words. Once the last word of a frame is complete, further data bits are ignored until the next frame sync.
- R4: Each completed word appears in `bufferOut` with the received word in bits 15:0 and bits 31:16 filled with copies of bit 15.
- R5: `readyOut` goes to 1 when a word enters the buffer. A one-cycle `rdStb` with no word arriving in the same cycle clears it.
- R6: `irqOut` is high for exactly one cycle, in the same cycle that a new word becomes visible in `bufferOut`, unless that word replaced an unread one.
- R7: If a word completes while `readyOut` is 1 and `rdStb` is low, `overrunOut` becomes 1 and stays 1 until reset, and the newer word replaces the old one in the buffer.
- R8: A frame sync that arrives before all words of the current frame are complete sets the sticky `syncErrOut`, throws away the partial word and restarts reception on the new frame.
- R9: A frame sync that arrives after a frame has completed does not set `syncErrOut`. A sync held high across several bit periods counts as a single frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rxReset | input | 1 | Synchronous active-high reset that holds the receiver idle |
| bitClk | input | 1 | External serial bit clock |
| frameSync | input | 1 | External active-high frame sync |
| serData | input | 1 | Serial data line |
| rdStb | input | 1 | Host read strobe; consumes the buffered word |
| bufferOut | output | 32 | Last received word, right-justified and sign-extended |
| readyOut | output | 1 | An unread word is in the buffer |
| irqOut | output | 1 | One-cycle pulse when a new word becomes ready |
| overrunOut | output | 1 | Sticky: an unread word was overwritten |
| syncErrOut | output | 1 | Sticky: a frame sync arrived too early |

## Verification
The bench builds the block with its defaults: 16-bit words, two words per frame and a two-stage input synchronizer. It drives a bit clock with four system cycles per half period. That is slow enough for every synchronized edge to be seen, and fast enough for dozens of frames to fit in a short run. The small word count brings several corners within reach with only a few frames. An overrun happens when the host skips the first of the two words. A premature sync can land in the middle of the first word. The sign-extension boundary words 0x8000 and 0x7FFF are covered by directed frames.

// File: rtl/frx_pkg.sv
package frx_pkg;

  // strobes passed from the sequencing control to the datapath
  typedef struct packed {
    logic shiftEn;     // take the sampled data bit into the shift register
    logic loadWord;    // this bit completes a word: move it to the buffer
    logic setSyncErr;  // a frame sync cut the current frame short
  } frx_strobe_t;

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chainQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chainQ[s] <= '0;
          else     chainQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chainQ[s] <= '0;
          else     chainQ[s] <= chainQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];

endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int WORD_BITS       = 16,
  parameter int WORDS_PER_FRAME = 2
) (
  input  logic        clk,
  input  logic        rxReset,
  input  logic        bitClkS,
  input  logic        fsS,
  output frx_strobe_t stb
);

  localparam int BIT_CNT_W  = $clog2(WORD_BITS);
  localparam int WORD_CNT_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
  localparam logic [BIT_CNT_W-1:0]  LAST_BIT  = BIT_CNT_W'(WORD_BITS - 1);
  localparam logic [WORD_CNT_W-1:0] LAST_WORD = WORD_CNT_W'(WORDS_PER_FRAME - 1);

  logic                  bitClkPrevQ;
  logic                  fsPrevQ, fsPrevD;
  logic                  busyQ, busyD;
  logic [BIT_CNT_W-1:0]  bitCntQ, bitCntD;
  logic [WORD_CNT_W-1:0] wordCntQ, wordCntD;
  logic                  bitFall;
  logic                  fsRise;

  assign bitFall = bitClkPrevQ && !bitClkS;
  assign fsRise  = bitFall && fsS && !fsPrevQ;

  always_comb begin
    stb      = '0;
    busyD    = busyQ;
    bitCntD  = bitCntQ;
    wordCntD = wordCntQ;
    fsPrevD  = fsPrevQ;
    if (bitFall) begin
      fsPrevD = fsS;
      if (fsRise) begin
        // new frame; the bit on this edge is the delay slot
        stb.setSyncErr = busyQ;
        busyD    = 1'b1;
        bitCntD  = '0;
        wordCntD = '0;
      end else if (busyQ) begin
        stb.shiftEn = 1'b1;
        if (bitCntQ == LAST_BIT) begin
          stb.loadWord = 1'b1;
          bitCntD      = '0;
          if (wordCntQ == LAST_WORD) begin
            busyD    = 1'b0;
            wordCntD = '0;
          end else begin
            wordCntD = wordCntQ + 1'b1;
          end
        end else begin
          bitCntD = bitCntQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rxReset) begin
      bitClkPrevQ <= 1'b0;
      fsPrevQ     <= 1'b0;
      busyQ       <= 1'b0;
      bitCntQ     <= '0;
      wordCntQ    <= '0;
    end else begin
      bitClkPrevQ <= bitClkS;
      fsPrevQ     <= fsPrevD;
      busyQ       <= busyD;
      bitCntQ     <= bitCntD;
      wordCntQ    <= wordCntD;
    end
  end

endmodule

// File: rtl/frx_dpath.sv
module frx_dpath
  import frx_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int OUT_BITS  = 32
) (
  input  logic                clk,
  input  logic                rxReset,
  input  logic                dataS,
  input  logic                rdStb,
  input  frx_strobe_t         stb,
  output logic [OUT_BITS-1:0] bufferOut,
  output logic                readyOut,
  output logic                irqOut,
  output logic                overrunOut,
  output logic                syncErrOut
);

  localparam int EXT_BITS = OUT_BITS - WORD_BITS;

  logic [WORD_BITS-1:0] shiftQ;
  logic [WORD_BITS-1:0] nextWord;
  logic [OUT_BITS-1:0]  bufferQ;
  logic                 readyQ, irqQ, overrunQ, syncErrQ;

  assign nextWord = {shiftQ[WORD_BITS-2:0], dataS};

  always_ff @(posedge clk) begin
    if (rxReset) begin
      shiftQ   <= '0;
      bufferQ  <= '0;
      readyQ   <= 1'b0;
      irqQ     <= 1'b0;
      overrunQ <= 1'b0;
      syncErrQ <= 1'b0;
    end else begin
      if (stb.shiftEn) shiftQ <= nextWord;
      if (stb.loadWord) begin
        bufferQ <= {{EXT_BITS{nextWord[WORD_BITS-1]}}, nextWord};
        readyQ  <= 1'b1;
        irqQ    <= !readyQ || rdStb;
        if (readyQ && !rdStb) overrunQ <= 1'b1;
      end else begin
        irqQ <= 1'b0;
        if (rdStb) readyQ <= 1'b0;
      end
      if (stb.setSyncErr) syncErrQ <= 1'b1;
    end
  end

  assign bufferOut  = bufferQ;
  assign readyOut   = readyQ;
  assign irqOut     = irqQ;
  assign overrunOut = overrunQ;
  assign syncErrOut = syncErrQ;

endmodule

// File: rtl/framed_serial_rx.sv
module framed_serial_rx
  import frx_pkg::*;
#(
  parameter int WORD_BITS       = 16,
  parameter int WORDS_PER_FRAME = 2,
  parameter int OUT_BITS        = 32,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                clk,
  input  logic                rxReset,
  input  logic                bitClk,
  input  logic                frameSync,
  input  logic                serData,
  input  logic                rdStb,
  output logic [OUT_BITS-1:0] bufferOut,
  output logic                readyOut,
  output logic                irqOut,
  output logic                overrunOut,
  output logic                syncErrOut
);

  logic [2:0]  syncLines;
  frx_strobe_t stb;

  frx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rxReset),
    .asyncIn ({bitClk, frameSync, serData}),
    .syncOut (syncLines)
  );

  frx_ctrl #(.WORD_BITS(WORD_BITS), .WORDS_PER_FRAME(WORDS_PER_FRAME)) u_ctrl (
    .clk     (clk),
    .rxReset (rxReset),
    .bitClkS (syncLines[2]),
    .fsS     (syncLines[1]),
    .stb     (stb)
  );

  frx_dpath #(.WORD_BITS(WORD_BITS), .OUT_BITS(OUT_BITS)) u_dpath (
    .clk        (clk),
    .rxReset    (rxReset),
    .dataS      (syncLines[0]),
    .rdStb      (rdStb),
    .stb        (stb),
    .bufferOut  (bufferOut),
    .readyOut   (readyOut),
    .irqOut     (irqOut),
    .overrunOut (overrunOut),
    .syncErrOut (syncErrOut)
  );

endmodule

// File: rtl/frx_checker.sv
module frx_checker (
  input logic clk,
  input logic rxReset,
  input logic rdStb,
  input logic loadWord,
  input logic readyOut,
  input logic irqOut,
  input logic overrunOut,
  input logic syncErrOut
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rxReset |=> (!readyOut && !irqOut && !overrunOut && !syncErrOut));

  // R5
  ready_set_chk: assert property (@(posedge clk) disable iff (rxReset)
    loadWord |=> readyOut);

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (rxReset)
    (rdStb && !loadWord) |=> !readyOut);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rxReset)
    irqOut |=> !irqOut);

  // R6
  irq_ready_chk: assert property (@(posedge clk) disable iff (rxReset)
    irqOut |-> readyOut);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rxReset)
    (loadWord && readyOut && !rdStb) |=> overrunOut);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rxReset)
    overrunOut |=> overrunOut);

  // R8
  sync_sticky_chk: assert property (@(posedge clk) disable iff (rxReset)
    syncErrOut |=> syncErrOut);

endmodule

bind framed_serial_rx frx_checker u_chk (
  .clk        (clk),
  .rxReset    (rxReset),
  .rdStb      (rdStb),
  .loadWord   (stb.loadWord),
  .readyOut   (readyOut),
  .irqOut     (irqOut),
  .overrunOut (overrunOut),
  .syncErrOut (syncErrOut)
);

// File: tb/framed_serial_rx_bench.sv
module framed_serial_rx_bench;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rxReset = 1'b1;
  logic        bitClk = 1'b0;
  logic        frameSync = 1'b0;
  logic        serData = 1'b0;
  logic        rdStb = 1'b0;
  logic [31:0] bufferOut;
  logic        readyOut, irqOut, overrunOut, syncErrOut;

  int          checks = 0;
  int          errors = 0;
  int          irqCnt = 0;
  bit          autoRead = 1'b1;
  bit          done = 1'b0;
  logic [31:0] got[$];

  always #5 clk = ~clk;

  framed_serial_rx u_framed_serial_rx (
    .clk(clk), .rxReset(rxReset), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .rdStb(rdStb), .bufferOut(bufferOut),
    .readyOut(readyOut), .irqOut(irqOut), .overrunOut(overrunOut),
    .syncErrOut(syncErrOut)
  );

  function automatic logic [31:0] sext(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // host side: count interrupts, read words while autoRead is on
  initial begin
    forever begin
      @(negedge clk);
      if (irqOut) irqCnt++;
      if (autoRead) begin
        if (irqOut) begin
          got.push_back(bufferOut);
          rdStb = 1'b1;
        end else begin
          rdStb = 1'b0;
        end
      end
    end
  end

  task automatic slot(input logic fsV, input logic dV);
    bitClk = 1'b1; frameSync = fsV; serData = dV;
    repeat (HALF) @(negedge clk);
    bitClk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // fsHold: number of extra slots the sync stays high into the data
  task automatic frame(input logic [15:0] w0, input logic [15:0] w1, input int fsHold);
    logic [31:0] bits;
    bits = {w0, w1};
    slot(1'b1, 1'($urandom));
    for (int b = 31; b >= 0; b--) slot((31 - b) < fsHold, bits[b]);
    for (int i = 0; i < 3; i++) slot(1'b0, 1'($urandom));
    repeat (8) @(negedge clk);
  endtask

  task automatic checkFrame(input string req, input logic [15:0] w0, input logic [15:0] w1);
    chk({req, " word count"}, 32'(got.size()), 32'd2);
    if (got.size() == 2) begin
      chk({req, " word 0"}, got[0], sext(w0));
      chk({req, " word 1"}, got[1], sext(w1));
    end
    got.delete();
  endtask

  initial begin
    logic [15:0] a, b;
    int          irqBase;
    void'($urandom(32'd2718));
    repeat (6) @(negedge clk);
    // R1: reset state
    chk("R1 ready", 32'(readyOut), 0);
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 overrun", 32'(overrunOut), 0);
    chk("R1 syncErr", 32'(syncErrOut), 0);
    chk("R1 buffer", bufferOut, 0);
    rxReset = 1'b0;
    repeat (4) @(negedge clk);

    // R4 directed sign-extension boundaries, R2/R3 capture order
    frame(16'h8000, 16'h7FFF, 0);
    checkFrame("R4 boundary", 16'h8000, 16'h7FFF);
    frame(16'hFFFF, 16'h0001, 0);
    checkFrame("R3 R4 extremes", 16'hFFFF, 16'h0001);

    // R2 R3 random frames; R9 back-to-back syncs after complete frames
    for (int n = 0; n < 12; n++) begin
      a = 16'($urandom); b = 16'($urandom);
      frame(a, b, 0);
      checkFrame("R2 R3 random", a, b);
    end
    chk("R9 no sync error after full frames", 32'(syncErrOut), 0);
    chk("R7 no overrun with prompt reads", 32'(overrunOut), 0);
    chk("R5 ready cleared by reads", 32'(readyOut), 0);

    // R9 sync held high into the data bits
    a = 16'h5A3C; b = 16'hC3A5;
    frame(a, b, 3);
    checkFrame("R9 long sync", a, b);
    chk("R9 long sync no error", 32'(syncErrOut), 0);

    // R6 interrupt count per word
    irqBase = irqCnt;
    a = 16'($urandom); b = 16'($urandom);
    frame(a, b, 0);
    checkFrame("R6 frame", a, b);
    chk("R6 one irq per word", 32'(irqCnt - irqBase), 2);

    // R7 overrun: host skips both words
    autoRead = 1'b0;
    rdStb = 1'b0;
    irqBase = irqCnt;
    a = 16'h1234; b = 16'hFEDC;
    frame(a, b, 0);
    chk("R7 overrun set", 32'(overrunOut), 1);
    chk("R7 newer word kept", bufferOut, sext(b));
    chk("R5 ready held", 32'(readyOut), 1);
    chk("R6 no irq on overwrite", 32'(irqCnt - irqBase), 1);
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0;
    @(negedge clk);
    chk("R5 ready cleared", 32'(readyOut), 0);
    chk("R7 overrun sticky", 32'(overrunOut), 1);
    autoRead = 1'b1;

    // R8 premature sync after 10 bits of the first word
    slot(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) slot(1'b0, 1'($urandom));
    a = 16'h0F0F; b = 16'h8421;
    frame(a, b, 0);
    chk("R8 sync error set", 32'(syncErrOut), 1);
    checkFrame("R8 restart", a, b);
    frame(16'h4444, 16'h5555, 0);
    chk("R8 sync error sticky", 32'(syncErrOut), 1);
    checkFrame("R8 after restart", 16'h4444, 16'h5555);

    // R1 reset holds the block idle and clears flags
    rxReset = 1'b1;
    irqBase = irqCnt;
    frame(16'h7777, 16'h9999, 0);
    chk("R1 idle irq", 32'(irqCnt - irqBase), 0);
    chk("R1 idle ready", 32'(readyOut), 0);
    chk("R1 idle buffer", bufferOut, 0);
    chk("R1 overrun cleared", 32'(overrunOut), 0);
    chk("R1 syncErr cleared", 32'(syncErrOut), 0);
    chk("R1 no words", 32'(got.size()), 0);
    got.delete();
    rxReset = 1'b0;
    repeat (4) @(negedge clk);
    frame(16'h2468, 16'hACE0, 0);
    checkFrame("R1 after release", 16'h2468, 16'hACE0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule